// File: doc/BRIEF.md
# Banked Two-Port Input Capture Controller

This block captures parallel input words on two ports, numbered 0 and 2. Each port takes a new word either on an internal capture tick that runs at 1 MHz, or on the rising edge of its own external capture strobe. A data-available marker is raised whenever a port latches a word. The marker is cleared when software reads that port's data word.

Both ports are configured through a single command address. A bank-select bit in the control register decides which port that address reaches. Each port has three command bits:

- bit 0 enables its edge interrupt;
- bit 1 picks the capture source (0 internal tick, 1 external strobe);
- bit 2 enables its data-available interrupt.

The single interrupt output is gated by a global enable in the control register. The data-available interrupt is masked in hardware while a port captures on the internal tick. This stops a request from being posted every microsecond.

When a port is switched from internal to external capture, its marker is forced clear. A capture that coincides with that write is discarded. The strobe and edge inputs are asynchronous and are synchronized before use.

Top module: `banked_capture_ctrl`

## Requirements
- R1: After reset, all command bits, data-available markers, edge-pending flags, the bank select and the global enable are 0, and `irq` is 0.
- R2: A read of the command address (2'h1 on `bus_addr`, i.e. 3'd1) returns ones in bits 15 to 3 and the selected port's bits 2:0 below them. Writes to bits 15 to 3 of that address have no effect.
- R3: Control register (address 3'd0) bit 0 is the bank select: 0 routes the command address to port 0 and 1 routes it to port 2. Each port keeps its own command bits, whatever the bank select.
- R4: With command bit 1 = 0, a port latches its input word once every TICK_DIV clock cycles (1 MHz at the default) and sets its marker.
- R5: With command bit 1 = 1, a port latches its input word once per rising edge of its strobe, counted after a two-flop synchronizer. A strobe held high causes only one capture, and internal ticks are ignored.
- R6: Reading a port's data word (address 3'd2 for port 0, 3'd3 for port 2) clears that port's marker. Status address 3'd4 reads the markers in bit 0 (port 0) and bit 1 (port 2).
- R7: A command write that changes bit 1 from 0 to 1 clears that port's marker on the next cycle. A capture in the cycle of the write is discarded.
- R8: A port's data-available request is asserted when its marker is set, command bit 2 is 1 and command bit 1 is 1.
- R9: While command bit 1 is 0, the port raises no data-available request, even with bit 2 set.
- R10: A synchronized rising edge on a port's edge input sets its edge-pending flag, which is read at status bits 2 (port 0) and 3 (port 2). Writing 1 to that status bit clears it. A set flag requests an interrupt only when command bit 0 is 1.
- R11: `irq` is 1 only when control bit 6 (global enable) is 1 and at least one port request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| p0_din | input | DATA_W | Port 0 input word |
| p2_din | input | DATA_W | Port 2 input word |
| p0_strobe | input | 1 | Port 0 external capture strobe (async) |
| p2_strobe | input | 1 | Port 2 external capture strobe (async) |
| p0_edge | input | 1 | Port 0 edge interrupt input (async) |
| p2_edge | input | 1 | Port 2 edge interrupt input (async) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench writes different command values through each bank and reads them back. A design that ignored the bank select would show port 2's bits under port 0. A design that stored the upper write bits would return something other than all ones.

The bench holds an external strobe high across a data read. A design that captured on level rather than on edge would re-set the marker while the strobe stays high.

The bench also enables the data-available interrupt while a port is on the internal tick. A design without the hardware mask would raise `irq`.

Finally, the bench switches a port with a set marker over to external capture. A design that kept the marker would still report data available.

// File: rtl/bcc_pkg.sv
// Package: shared constants and types for the banked capture controller.
// Assumes a 16-bit register bus; the command register format depends on it.
package bcc_pkg;
    localparam int REG_W = 16;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMD   = 3'd1;
    localparam logic [2:0] A_DATA0 = 3'd2;
    localparam logic [2:0] A_DATA2 = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;

    localparam int CTRL_BANK_BIT = 0;
    localparam int CTRL_GIE_BIT  = 6;

    // Per-port command bits; packed order matches bits 2..0 of the register.
    typedef struct packed {
        logic dav_en;   // bit 2
        logic ext_sel;  // bit 1
        logic edge_en;  // bit 0
    } cmd_t;
endpackage

// File: rtl/bcc_edge_sync.sv
// Module: two-flop synchronizer followed by a rising-edge detector, W lanes.
// Assumes inputs are asynchronous levels; output pulses one cycle per rise.
module bcc_edge_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Synchronize and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising edge after synchronization.
    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/bcc_tick_gen.sv
// Module: internal capture tick, one pulse every TICK_DIV clock cycles.
// Assumes TICK_DIV >= 2.
module bcc_tick_gen #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bcc_capture_lane.sv
// Module: one input port: command bits, data latch, data-available marker,
// edge-pending flag and its interrupt request.
// Assumes strobe_rise / edge_rise are synchronized single-cycle pulses.
module bcc_capture_lane
    import bcc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              strobe_rise,
    input  logic              edge_rise,
    input  logic              cmd_we,
    input  cmd_t              cmd_wdata,
    input  logic              data_rd,
    input  logic              edge_clr,
    input  logic [DATA_W-1:0] din,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] dout,
    output logic              dav,
    output logic              edge_pend,
    output logic              irq_req
);
    cmd_t              cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              dav_q, edge_q;
    logic              switching, cap;

    // Internal-to-external selection change in this cycle.
    assign switching = cmd_we && cmd_wdata.ext_sel && !cmd_q.ext_sel;
    // Capture event from the selected source, dropped during a switch.
    assign cap = (cmd_q.ext_sel ? strobe_rise : tick) && !switching;

    // Command bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= cmd_wdata;
    end

    // Data latch.
    always_ff @(posedge clk) begin
        if (!rst_n)   data_q <= '0;
        else if (cap) data_q <= din;
    end

    // Data-available marker: switch clears, capture sets, read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         dav_q <= 1'b0;
        else if (switching) dav_q <= 1'b0;
        else if (cap)       dav_q <= 1'b1;
        else if (data_rd)   dav_q <= 1'b0;
    end

    // Edge-pending flag: new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         edge_q <= 1'b0;
        else if (edge_rise) edge_q <= 1'b1;
        else if (edge_clr)  edge_q <= 1'b0;
    end

    // Requests; the data-available source is masked on the internal tick.
    assign irq_req = (dav_q && cmd_q.dav_en && cmd_q.ext_sel)
                   || (edge_q && cmd_q.edge_en);

    assign cmd       = cmd_q;
    assign dout      = data_q;
    assign dav       = dav_q;
    assign edge_pend = edge_q;

    // R5
    ext_capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.ext_sel && strobe_rise && !switching) |=> dav_q);
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !cap && !switching) |=> !dav_q);
    // R7
    switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switching |=> !dav_q);
    // R10
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rise |=> edge_q);
endmodule

// File: rtl/banked_capture_ctrl.sv
// Module: top of the banked two-port capture controller. Decodes the register
// bus, routes the banked command address, and combines interrupt requests.
// Assumes one bus access per cycle; read side effects happen on bus_rd.
module banked_capture_ctrl
    import bcc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3,
    parameter int TICK_DIV = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [DATA_W-1:0] p0_din,
    input  logic [DATA_W-1:0] p2_din,
    input  logic              p0_strobe,
    input  logic              p2_strobe,
    input  logic              p0_edge,
    input  logic              p2_edge,
    output logic              irq
);
    localparam int NP = 2;

    logic              bank_q, gie_q, tick;
    logic [2:0]        a3;
    logic [NP-1:0]     strobe_rise, edge_rise, cmd_we, data_rd, edge_clr;
    logic [NP-1:0]     dav, edge_pend, req;
    cmd_t              cmd   [NP];
    logic [DATA_W-1:0] din   [NP];
    logic [DATA_W-1:0] dout  [NP];
    logic              unused_wdata;

    assign a3           = 3'(bus_addr);
    assign unused_wdata = ^{bus_wdata[15:7], bus_wdata[5:4]};
    assign din[0]       = p0_din;
    assign din[1]       = p2_din;

    // Control register: bank select and global interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            gie_q  <= 1'b0;
        end else if (bus_wr && a3 == A_CTRL) begin
            bank_q <= bus_wdata[CTRL_BANK_BIT];
            gie_q  <= bus_wdata[CTRL_GIE_BIT];
        end
    end

    bcc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    bcc_edge_sync #(.W(2 * NP)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({p2_edge, p0_edge, p2_strobe, p0_strobe}),
        .rise({edge_rise, strobe_rise})
    );

    generate
        for (genvar i = 0; i < NP; i++) begin : g_lane
            // Per-lane decode of banked command write, data read and W1C clear.
            assign cmd_we[i]   = bus_wr && a3 == A_CMD && bank_q == i[0];
            assign data_rd[i]  = bus_rd && a3 == (A_DATA0 + 3'(i));
            assign edge_clr[i] = bus_wr && a3 == A_STAT && bus_wdata[2 + i];

            bcc_capture_lane #(.DATA_W(DATA_W)) u_lane (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .strobe_rise(strobe_rise[i]), .edge_rise(edge_rise[i]),
                .cmd_we(cmd_we[i]), .cmd_wdata(cmd_t'(bus_wdata[2:0])),
                .data_rd(data_rd[i]), .edge_clr(edge_clr[i]),
                .din(din[i]), .cmd(cmd[i]), .dout(dout[i]),
                .dav(dav[i]), .edge_pend(edge_pend[i]), .irq_req(req[i])
            );
        end
    endgenerate

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (a3)
            A_CTRL: begin
                bus_rdata[CTRL_BANK_BIT] = bank_q;
                bus_rdata[CTRL_GIE_BIT]  = gie_q;
            end
            A_CMD:   bus_rdata = {13'h1FFF, cmd[bank_q]};
            A_DATA0: bus_rdata = 16'(dout[0]);
            A_DATA2: bus_rdata = 16'(dout[1]);
            A_STAT:  bus_rdata = {12'h000, edge_pend, dav};
            default: bus_rdata = '0;
        endcase
    end

    // Global gate on the combined request.
    assign irq = gie_q && (|req);

    // R11
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq);
    // R2
    cmd_upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a3 == A_CMD) |-> (bus_rdata[15:3] == 13'h1FFF));
    // R9
    int_tick_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd[0].ext_sel && !cmd[1].ext_sel && !cmd[0].edge_en
         && !cmd[1].edge_en) |-> !irq);
endmodule

// File: tb/banked_capture_ctrl_bench.sv
`timescale 1ns/1ps
module banked_capture_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] p0_din = 16'hA5A5, p2_din = 16'h3C3C;
    logic        p0_strobe = 1'b0, p2_strobe = 1'b0;
    logic        p0_edge = 1'b0, p2_edge = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        logic [15:0] msk;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    banked_capture_ctrl u_banked_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .p0_din(p0_din), .p2_din(p2_din), .p0_strobe(p0_strobe),
        .p2_strobe(p2_strobe), .p0_edge(p0_edge), .p2_edge(p2_edge),
        .irq(irq)
    );

    // Monitor: pop expected read values and compare mid low phase.
    always @(negedge clk) begin
        #1;
        if (bus_rd && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if ((bus_rdata & it.msk) !== (it.exp & it.msk)) begin
                errors++;
                $display("FAIL %s: read %h expected %h (mask %h)",
                         it.tag, bus_rdata, it.exp, it.msk);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: push the expected item and issue the read.
    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp,
                          input logic [15:0] msk, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        sb_q.push_back('{exp: exp, msk: msk, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic pulse_p2_strobe();
        p2_strobe = 1'b1; idle(3); p2_strobe = 1'b0; idle(6);
    endtask

    task automatic pulse_p0_edge();
        p0_edge = 1'b1; idle(3); p0_edge = 1'b0; idle(6);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(3'd0, 16'h0000, 16'hFFFF, "R1 control");
        rd_chk(3'd1, 16'hFFF8, 16'hFFFF, "R1 command");
        rd_chk(3'd4, 16'h0000, 16'hFFFF, "R1 status");
        chk_irq(1'b0, "R1 irq");
        // R2 format and ignored upper bits
        wr(3'd1, 16'h0005);
        rd_chk(3'd1, 16'hFFFD, 16'hFFFF, "R2 stored bits");
        wr(3'd1, 16'hFFF8);
        rd_chk(3'd1, 16'hFFF8, 16'hFFFF, "R2 upper ignored");
        // R3 banking
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0003);
        rd_chk(3'd1, 16'hFFFB, 16'hFFFF, "R3 port2 bank");
        wr(3'd0, 16'h0000);
        rd_chk(3'd1, 16'hFFF8, 16'hFFFF, "R3 port0 kept");
        wr(3'd0, 16'h0001);
        // R4 internal capture on port 0
        idle(300);
        rd_chk(3'd4, 16'h0001, 16'h0001, "R4 marker");
        rd_chk(3'd2, 16'hA5A5, 16'hFFFF, "R4 data");
        rd_chk(3'd4, 16'h0000, 16'h0002, "R5 no strobe no marker");
        // R5 external capture on port 2
        pulse_p2_strobe();
        rd_chk(3'd4, 16'h0002, 16'h0002, "R5 marker");
        rd_chk(3'd3, 16'h3C3C, 16'hFFFF, "R5 data");
        p2_din = 16'h1234;
        idle(300);
        rd_chk(3'd4, 16'h0000, 16'h0002, "R6 read cleared");
        rd_chk(3'd3, 16'h3C3C, 16'hFFFF, "R5 tick ignored");
        p2_strobe = 1'b1; idle(6);
        rd_chk(3'd3, 16'h1234, 16'hFFFF, "R5 second capture");
        idle(4);
        rd_chk(3'd4, 16'h0000, 16'h0002, "R5 level no recapture");
        p2_strobe = 1'b0; idle(4);
        // R8 / R11 data-available interrupt on port 2
        wr(3'd1, 16'h0007);
        pulse_p2_strobe();
        chk_irq(1'b0, "R11 gated off");
        wr(3'd0, 16'h0041);
        chk_irq(1'b1, "R8 dav irq");
        rd_chk(3'd3, 16'h1234, 16'hFFFF, "R8 data");
        chk_irq(1'b0, "R6 read drops irq");
        // R9 masked in internal mode on port 0
        wr(3'd0, 16'h0040);
        wr(3'd1, 16'h0004);
        idle(300);
        rd_chk(3'd4, 16'h0001, 16'h0001, "R9 marker set");
        chk_irq(1'b0, "R9 masked");
        // R7 switch clears marker
        wr(3'd1, 16'h0006);
        rd_chk(3'd4, 16'h0000, 16'h0001, "R7 switch cleared");
        chk_irq(1'b0, "R7 irq");
        // R10 edge interrupt on port 0
        wr(3'd1, 16'h0003);
        pulse_p0_edge();
        rd_chk(3'd4, 16'h0004, 16'h0004, "R10 pending");
        chk_irq(1'b1, "R10 edge irq");
        wr(3'd4, 16'h0004);
        rd_chk(3'd4, 16'h0000, 16'h0004, "R10 w1c");
        chk_irq(1'b0, "R10 cleared");
        wr(3'd1, 16'h0002);
        pulse_p0_edge();
        rd_chk(3'd4, 16'h0004, 16'h0004, "R10 pending disabled");
        chk_irq(1'b0, "R10 edge disabled");
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0003);
        chk_irq(1'b0, "R11 global off");
        wr(3'd0, 16'h0040);
        chk_irq(1'b1, "R11 global on");
        idle(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule